// File: doc/BRIEF.md
# Frame-Word Hunter and Checked Block Deframer

This block sits behind a demodulator and its clock recovery. It receives one recovered bit per strobe and looks for either of two 16-bit frame words. A match sets a flag for that word. The block then switches from hunting to block reception. In block reception it packs the incoming bits into bytes, first bit into bit 7, and hands each finished byte to the host through a one-byte receive register with a data-ready flag.

A block is eight bytes: six message bytes followed by two check bytes. While the block is arriving, a polynomial divider and a parity accumulator process it. When the last bit lands, a checksum-true flag reports whether the block was intact. At that same bit the host's format input is sampled. A set input starts another checked block at once. A clear input sends the block back to hunting for a new frame word.

The host clears flags with single-cycle read strobes. An active-low interrupt request combines the flags that are allowed to interrupt.

Top module: `frame_deframer`

## Requirements
- R1: After synchronous reset, rx_byte is 0x00, all four flags are low and irq_n is high.
- R2: With rx_enable high and the block hunting, sync_seen is set on the clock edge that accepts the 16th bit of the word 1100010011010111. The leftmost bit is received first.
- R3: Under the same conditions, synt_seen is set on the 16th bit of the word 0011101100101000. The leftmost bit is received first.
- R4: No byte is loaded and data_ready stays clear until a frame word has been matched.
- R5: After a match, every eighth accepted bit loads rx_byte and sets data_ready on the same edge. The first received bit of the byte is in bit 7.
- R6: While a block is being received, bit patterns equal to either frame word do not set sync_seen or synt_seen.
- R7: On the load of the eighth byte of a block, chk_true is set when both tests pass, and is clear otherwise. The first test: bits 1 to 63, with bit 63 inverted, divided modulo 2 by x^15+x^14+x^13+x^11+x^4+x^2+1, leave a zero remainder. The second test: bit 64 equals the XOR of bits 1 to 63. Loading any other byte clears chk_true.
- R8: At the 64th bit of a block, fmt_continue high starts a further eight-byte block with no frame word. Low returns the block to hunting, with the search window cleared.
- R9: data_ready and chk_true clear only when a status_rd pulse taken while data_ready is set is followed by a data_rd pulse, with no new byte loaded in between. A data_rd alone clears nothing. A new load takes priority over a clear on the same edge.
- R10: sync_seen and synt_seen clear on a status_rd pulse, unless the same edge sets them.
- R11: While rx_enable is low, all four flags are held clear, the search window is emptied and the block returns to hunting. rx_byte keeps its value.
- R12: irq_n is low exactly when data_ready, sync_seen or synt_seen is set. chk_true never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable; low clears and idles the block |
| bit_valid | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit, valid with bit_valid |
| fmt_continue | input | 1 | Host format bit sampled at the end of each block |
| status_rd | input | 1 | One-cycle pulse: host read of the status flags |
| data_rd | input | 1 | One-cycle pulse: host read of rx_byte |
| rx_byte | output | 8 | Last received byte |
| data_ready | output | 1 | A byte is waiting in rx_byte |
| chk_true | output | 1 | Block check passed (with the eighth byte) |
| sync_seen | output | 1 | First frame word detected |
| synt_seen | output | 1 | Second frame word detected |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A behavioural model in the bench is compared with the outputs on every clock. Several stimulus patterns drive both. An alternating preamble and all-ones noise show that nothing is delivered before a frame word is matched. Each frame word is then sent alone, which separates the two comparators. A block whose message bytes contain both frame words shows that hunting is really off during reception. An intact block and a block with one flipped bit, sent back to back under a set format bit, separate a passing check from a failing one and show continuation without a new frame word. A block read with buffer reads only, and a disable in mid-block followed by a fresh frame word, exercise the clear ordering and the recovery path.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    localparam int FW_BITS = 16;
    localparam logic [FW_BITS-1:0] FW_SYNC_WORD = 16'hC4D7;
    localparam logic [FW_BITS-1:0] FW_SYNT_WORD = 16'h3B28;

    localparam int CHK_W = 15;
    localparam logic [CHK_W-1:0] CHK_POLY = 15'h6815;

    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_BLOCK = 1'b1
    } dfr_state_e;

    typedef enum logic [1:0] {
        FW_NONE = 2'd0,
        FW_SYNC = 2'd1,
        FW_SYNT = 2'd2
    } fw_hit_e;

    typedef struct packed {
        logic data_ready;
        logic chk_true;
        logic sync_seen;
        logic synt_seen;
    } dfr_flags_t;

    // One step of plain modulo-2 long division by the check polynomial.
    function automatic logic [CHK_W-1:0] div_step(input logic [CHK_W-1:0] rem,
                                                  input logic din);
        logic [CHK_W-1:0] nxt;
        nxt = {rem[CHK_W-2:0], din};
        if (rem[CHK_W-1])
            nxt = nxt ^ CHK_POLY;
        return nxt;
    endfunction

endpackage

// File: rtl/dfr_hunt.sv
module dfr_hunt
    import dfr_pkg::*;
#(
    parameter int W = FW_BITS,
    parameter logic [W-1:0] WORD_A = FW_SYNC_WORD,
    parameter logic [W-1:0] WORD_B = FW_SYNT_WORD
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    shift,
    input  logic    bit_in,
    output fw_hit_e hit
);

    logic [W-1:0] window_q;
    logic [W-1:0] window_nxt;

    assign window_nxt = {window_q[W-2:0], bit_in};

    always_comb begin
        hit = FW_NONE;
        if (shift) begin
            if (window_nxt == WORD_A)
                hit = FW_SYNC;
            else if (window_nxt == WORD_B)
                hit = FW_SYNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            window_q <= '0;
        else if (shift)
            window_q <= window_nxt;
    end

endmodule

// File: rtl/dfr_check.sv
module dfr_check
    import dfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             inv,
    input  logic             bit_in,
    output logic [CHK_W-1:0] rem,
    output logic             par
);

    logic [CHK_W-1:0] rem_q;
    logic             par_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem_q <= '0;
            par_q <= 1'b0;
        end else if (en) begin
            rem_q <= div_step(rem_q, bit_in ^ inv);
            par_q <= par_q ^ bit_in;
        end
    end

    assign rem = rem_q;
    assign par = par_q;

endmodule

// File: rtl/dfr_flags.sv
module dfr_flags
    import dfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       set_dr,
    input  logic       ct_val,
    input  logic       set_sync,
    input  logic       set_synt,
    input  logic       status_rd,
    input  logic       data_rd,
    output dfr_flags_t flags
);

    dfr_flags_t f_q;
    logic       armed_q;
    logic       clr_pair;

    assign clr_pair = data_rd && armed_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            f_q     <= '0;
            armed_q <= 1'b0;
        end else begin
            if (set_dr) begin
                f_q.data_ready <= 1'b1;
                f_q.chk_true   <= ct_val;
                armed_q        <= 1'b0;
            end else if (clr_pair) begin
                f_q.data_ready <= 1'b0;
                f_q.chk_true   <= 1'b0;
                armed_q        <= 1'b0;
            end else if (status_rd && f_q.data_ready) begin
                armed_q <= 1'b1;
            end

            if (set_sync)
                f_q.sync_seen <= 1'b1;
            else if (status_rd)
                f_q.sync_seen <= 1'b0;

            if (set_synt)
                f_q.synt_seen <= 1'b1;
            else if (status_rd)
                f_q.synt_seen <= 1'b0;
        end
    end

    assign flags = f_q;

    AST_CT_NEEDS_DR: assert property (@(posedge clk) disable iff (rst)
        f_q.chk_true |-> f_q.data_ready); // R7

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (f_q == '0)); // R11

    AST_DR_NO_LONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (en && f_q.data_ready && !armed_q && !status_rd) |=> f_q.data_ready); // R9

endmodule

// File: rtl/frame_deframer.sv
module frame_deframer
    import dfr_pkg::*;
#(
    parameter int BYTE_BITS   = 8,
    parameter int BLOCK_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_enable,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    input  logic                 fmt_continue,
    input  logic                 status_rd,
    input  logic                 data_rd,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 data_ready,
    output logic                 chk_true,
    output logic                 sync_seen,
    output logic                 synt_seen,
    output logic                 irq_n
);

    localparam int BLOCK_BITS = BLOCK_BYTES * BYTE_BITS;
    localparam int CW         = $clog2(BLOCK_BITS);
    localparam int BW         = $clog2(BYTE_BITS);

    dfr_state_e           st_q;
    logic [CW-1:0]        cnt_q;
    logic [BYTE_BITS-1:0] sh_q;
    logic [BYTE_BITS-1:0] byte_q;
    logic [BYTE_BITS-1:0] byte_nxt;

    logic             strobe, in_hunt, in_block;
    logic             last_bit, byte_end, ld;
    fw_hit_e          hit;
    logic             set_sync, set_synt, matched;
    logic [CHK_W-1:0] rem;
    logic             par;
    logic             ct_val;
    dfr_flags_t       flags;

    assign strobe   = rx_enable && bit_valid;
    assign in_hunt  = (st_q == ST_HUNT);
    assign in_block = (st_q == ST_BLOCK);
    assign last_bit = strobe && in_block && (cnt_q == CW'(BLOCK_BITS - 1));
    assign byte_end = (cnt_q[BW-1:0] == {BW{1'b1}});
    assign ld       = strobe && in_block && byte_end;
    assign byte_nxt = {sh_q[BYTE_BITS-2:0], bit_in};

    assign set_sync = (hit == FW_SYNC);
    assign set_synt = (hit == FW_SYNT);
    assign matched  = set_sync || set_synt;

    assign ct_val = last_bit && (rem == '0) && (par == bit_in);

    dfr_hunt u_hunt (
        .clk    (clk),
        .rst    (rst),
        .clr    (!rx_enable || matched),
        .shift  (strobe && in_hunt),
        .bit_in (bit_in),
        .hit    (hit)
    );

    dfr_check u_check (
        .clk    (clk),
        .rst    (rst),
        .clr    (!rx_enable || matched || last_bit),
        .en     (strobe && in_block && !last_bit),
        .inv    (cnt_q == CW'(BLOCK_BITS - 2)),
        .bit_in (bit_in),
        .rem    (rem),
        .par    (par)
    );

    dfr_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_enable),
        .set_dr    (ld),
        .ct_val    (ct_val),
        .set_sync  (set_sync),
        .set_synt  (set_synt),
        .status_rd (status_rd),
        .data_rd   (data_rd),
        .flags     (flags)
    );

    always_ff @(posedge clk) begin
        if (rst || !rx_enable) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (strobe) begin
            case (st_q)
                ST_HUNT: begin
                    if (matched) begin
                        st_q  <= ST_BLOCK;
                        cnt_q <= '0;
                    end
                end
                ST_BLOCK: begin
                    sh_q <= byte_nxt;
                    if (last_bit) begin
                        cnt_q <= '0;
                        if (!fmt_continue)
                            st_q <= ST_HUNT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            byte_q <= '0;
        else if (ld)
            byte_q <= byte_nxt;
    end

    assign rx_byte    = byte_q;
    assign data_ready = flags.data_ready;
    assign chk_true   = flags.chk_true;
    assign sync_seen  = flags.sync_seen;
    assign synt_seen  = flags.synt_seen;
    assign irq_n      = !(flags.data_ready || flags.sync_seen || flags.synt_seen);

    AST_BYTE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        (byte_q != $past(byte_q)) |-> flags.data_ready); // R5

    AST_FLAG_FROM_HUNT: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.sync_seen) || $rose(flags.synt_seen)) |-> $past(st_q) == ST_HUNT); // R6

    AST_HUNT_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (in_hunt && !matched) |=> $stable(byte_q)); // R4

endmodule

// File: tb/frame_deframer_bench.sv
module frame_deframer_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1, rx_enable = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
    logic       fmt_continue = 1'b0, status_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       data_ready, chk_true, sync_seen, synt_seen, irq_n;

    frame_deframer u_frame_deframer (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .bit_valid(bit_valid),
        .bit_in(bit_in), .fmt_continue(fmt_continue), .status_rd(status_rd),
        .data_rd(data_rd), .rx_byte(rx_byte), .data_ready(data_ready),
        .chk_true(chk_true), .sync_seen(sync_seen), .synt_seen(synt_seen),
        .irq_n(irq_n)
    );

    int    vectors = 0, fails = 0, cycles = 0;
    string phase = "R1 reset";
    bit    started = 0;

    // Behavioural reference model
    bit        m_hunt = 1;
    bit [15:0] m_win;
    int        m_n;
    bit [63:0] m_vec;
    bit [7:0]  m_cur, m_byte;
    bit        m_dr, m_ct, m_sync, m_synt, m_arm;

    function automatic bit block_ok(bit [63:0] v);
        bit [14:0] r = '0;
        bit p = 0;
        for (int i = 0; i < 63; i++) begin
            bit b = v[63 - i];
            bit top = r[14];
            p ^= b;
            if (i == 62) b = ~b;
            r = {r[13:0], b};
            if (top) r ^= 15'h6815;
        end
        return (r == 0) && (p == v[0]);
    endfunction

    function automatic bit [63:0] make_block(bit [47:0] d);
        bit [14:0] r = '0;
        bit [15:0] c;
        bit p;
        for (int i = 0; i < 63; i++) begin
            bit b = (i < 48) ? d[47 - i] : 1'b0;
            bit top = r[14];
            r = {r[13:0], b};
            if (top) r ^= 15'h6815;
        end
        c[15:1] = r;
        c[1] = ~c[1];
        p = ^d ^ ^c[15:1];
        c[0] = p;
        return {d, c};
    endfunction

    always @(posedge clk) begin
        bit set_dr, ctv, ss, st, clr;
        started <= 1;
        if (rst) begin
            m_hunt = 1; m_win = 0; m_n = 0; m_cur = 0; m_byte = 0;
            m_dr = 0; m_ct = 0; m_sync = 0; m_synt = 0; m_arm = 0;
        end else if (!rx_enable) begin
            m_hunt = 1; m_win = 0; m_n = 0; m_cur = 0;
            m_dr = 0; m_ct = 0; m_sync = 0; m_synt = 0; m_arm = 0;
        end else begin
            set_dr = 0; ctv = 0; ss = 0; st = 0;
            if (bit_valid) begin
                if (m_hunt) begin
                    m_win = {m_win[14:0], bit_in};
                    if (m_win == 16'hC4D7) ss = 1;
                    else if (m_win == 16'h3B28) st = 1;
                    if (ss || st) begin m_hunt = 0; m_n = 0; m_win = 0; end
                end else begin
                    m_vec[63 - m_n] = bit_in;
                    m_cur = {m_cur[6:0], bit_in};
                    m_n++;
                    if (m_n % 8 == 0) begin m_byte = m_cur; set_dr = 1; end
                    if (m_n == 64) begin
                        ctv = block_ok(m_vec);
                        m_n = 0;
                        if (!fmt_continue) m_hunt = 1;
                    end
                end
            end
            clr = data_rd && m_arm;
            if (set_dr) begin m_dr = 1; m_ct = ctv; m_arm = 0; end
            else if (clr) begin m_dr = 0; m_ct = 0; m_arm = 0; end
            else if (status_rd && m_dr) m_arm = 1;
            if (ss) m_sync = 1; else if (status_rd) m_sync = 0;
            if (st) m_synt = 1; else if (status_rd) m_synt = 0;
        end
    end

    task automatic cmp(string req, string nm, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (started) begin
            vectors++;
            cmp("R5", "rx_byte", rx_byte, m_byte);
            cmp("R4", "data_ready", data_ready, m_dr);
            cmp("R7", "chk_true", chk_true, m_ct);
            cmp("R2", "sync_seen", sync_seen, m_sync);
            cmp("R3", "synt_seen", synt_seen, m_synt);
            cmp("R12", "irq_n", irq_n, !(m_dr || m_sync || m_synt));
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(bit sr, bit dr);
        @(negedge clk); #1;
        bit_valid = 0; status_rd = sr; data_rd = dr;
    endtask

    // rdmode: 0 none, 1 status then buffer, 2 buffer only
    task automatic send(bit [63:0] v, int n, int rdmode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bit_valid = 1; bit_in = v[n - 1 - i]; status_rd = 0; data_rd = 0;
            if (i % 8 == 7 && rdmode == 1) begin idle(1, 0); idle(0, 1); end
            else if (i % 8 == 7 && rdmode == 2) begin idle(0, 1); idle(0, 0); end
            else begin idle(0, 0); idle(0, 0); end
            idle(0, 0);
        end
    endtask

    initial begin
        repeat (3) idle(0, 0);
        rst = 0;
        repeat (3) idle(0, 0);
        rx_enable = 1;
        phase = "R4 preamble and noise";
        send(64'hAAAA_AAAA, 32, 1);
        send(64'hFFFF_FFFF, 32, 1);
        phase = "R2 sync word";
        send(64'hC4D7, 16, 0);
        phase = "R10 status read clears frame flag";
        idle(1, 0); idle(0, 0);
        phase = "R5 R6 block with embedded frame words";
        fmt_continue = 0;
        send(make_block(48'h3B28_C4D7_5A01), 64, 1);
        phase = "R8 stop then R4 no delivery";
        send(64'h00FF_1234, 32, 1);
        phase = "R3 synt word";
        send(64'h3B28, 16, 1);
        phase = "R7 corrupted block, R8 continue";
        fmt_continue = 1;
        send(make_block(48'h1234_5678_9ABC) ^ 64'h0000_0100_0000_0000, 64, 1);
        fmt_continue = 0;
        phase = "R7 intact continued block, R9 buffer read only";
        send(make_block(48'hDEAD_BEEF_0F0F), 64, 2);
        idle(0, 1); idle(1, 0); idle(0, 1); idle(0, 0);
        phase = "R11 disable mid-block";
        send(64'hC4D7, 16, 1);
        send(64'h5555_5, 20, 1);
        rx_enable = 0;
        repeat (4) idle(1, 1);
        rx_enable = 1;
        send(64'hD7, 8, 1);
        phase = "R11 recover after enable";
        send(64'hC4D7, 16, 1);
        send(make_block(48'h0102_0304_0506), 64, 1);
        repeat (4) idle(0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule